// File: doc/BRIEF.md
# Late-Write Burst Buffer with Read Forwarding

This block sits between the write sequencer of a burst-of-four synchronous memory and its storage array. A write command and its burst base address are accepted on one clock edge. The four data beats follow later. Two beats are taken on each of the next two edges, one from a rise lane and one from a fall lane, and each beat carries its own active-low byte-write enables. A finished burst is not written to the array straight away. It waits in a two-entry buffer and goes to the array only when a later write command needs its slot.

The read side presents a burst address together with the array's burst for that address. The block returns the coherent burst. Any byte held enabled in one of the two buffers overrides the array byte, and the newer buffer overrides the older one. A read therefore sees the latest data even while that data has not yet reached the array.

Top module: `lwb_late_write`

## Requirements
- R1: After synchronous reset both buffers are empty: `fwd_hit` is 0, `arr_we` is 0, and `fwd_data` equals `rd_arr_data`.
- R2: With a write command sampled on edge t, beats 0 and 1 are taken from `din_rise` and `din_fall` on edge t+1, and beats 2 and 3 from the same lanes on edge t+2. Lane contents on any other edge have no effect. Commands are at least two cycles apart, so the last beat edge of one write may coincide with the next command.
- R3: Byte enables are active low, one bit per lane per beat. Beat k, lane j has data bits [k*W + j*LANE_W +: LANE_W] and enable/mask bit k*LANES + j. Only enabled bytes are written, and a beat with all enables high writes nothing.
- R4: Edges with no write command and no pending beats leave the buffered and committed contents unchanged, whatever the data and enable lanes carry.
- R5: A buffered burst is committed during the cycle of the second write command that follows it. In that cycle `arr_we` is 1, `arr_addr` is its address, `arr_data` is its data, and `arr_ben` (active high) is its collected byte mask. At no other time is `arr_we` 1.
- R6: When `rd_addr` matches a buffered address, `fwd_hit` is 1 and each enabled buffered byte replaces the array byte in `fwd_data`. When there is no match, `fwd_data` equals `rd_arr_data`.
- R7: When both buffers match `rd_addr`, the newer buffer's enabled bytes take priority over the older buffer's bytes.
- R8: A read in the cycle right after the last beat edge of a write returns all four beats of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Accepted write command |
| wr_addr | input | ADDR_W | Burst base address of the write |
| din_rise | input | LANE_W*LANES | Rise-lane beat (beat 0 or 2) |
| din_fall | input | LANE_W*LANES | Fall-lane beat (beat 1 or 3) |
| ben_rise_n | input | LANES | Active-low byte enables for the rise-lane beat |
| ben_fall_n | input | LANES | Active-low byte enables for the fall-lane beat |
| rd_addr | input | ADDR_W | Read burst address |
| rd_arr_data | input | 4*LANE_W*LANES | Array contents of the read burst |
| fwd_data | output | 4*LANE_W*LANES | Coherent read burst |
| fwd_hit | output | 1 | Read address matches a buffer |
| arr_we | output | 1 | Array burst write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | 4*LANE_W*LANES | Array write burst |
| arr_ben | output | 4*LANES | Array byte mask, active high |

## Verification
The bench reads partway through a write, after only beats 0 and 1 have arrived. A design that shifts the beat edges by one would return wrong halves at that point. It then writes the same address twice with mixed enable patterns, including a fully aborted beat. This exposes a wrong buffer priority or inverted enable polarity, because stale or aborted bytes would show in the merged read. It also checks the exact commit cycle and mask, and places a command on the same edge as the previous write's last beats. An early or late commit, or a shift that loses those final beats, would corrupt the array copy that later reads see once both buffers have drained. Junk on the lanes with all enables low, driven between writes, catches a design that captures beats outside their slots.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
    // beats per burst and beats taken on one clock edge
    localparam int BURST    = 4;
    localparam int PER_EDGE = 2;

    // which half of the burst the next edge captures
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } phase_e;

    function automatic int unsigned first_beat(phase_e ph);
        return (ph == PH_HI) ? PER_EDGE : 0;
    endfunction
endpackage

// File: rtl/lwb_slots.sv
module lwb_slots
    import lwb_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_valid,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [LANE_W*LANES-1:0]      din_rise,
    input  logic [LANE_W*LANES-1:0]      din_fall,
    input  logic [LANES-1:0]             ben_rise_n,
    input  logic [LANES-1:0]             ben_fall_n,
    output logic                         new_vld,
    output logic [ADDR_W-1:0]            new_addr,
    output logic [BURST*LANE_W*LANES-1:0] new_data,
    output logic [BURST*LANES-1:0]       new_mask,
    output logic                         old_vld,
    output logic [ADDR_W-1:0]            old_addr,
    output logic [BURST*LANE_W*LANES-1:0] old_data,
    output logic [BURST*LANES-1:0]       old_mask
);
    localparam int W  = LANE_W * LANES;
    localparam int BW = BURST * W;
    localparam int MW = BURST * LANES;

    phase_e          phase;
    int unsigned     fill_base;
    logic [BW-1:0]   fill_data;
    logic [MW-1:0]   fill_mask;

    // merge the beats of this edge into the newest slot
    always_comb begin
        fill_base = first_beat(phase);
        fill_data = new_data;
        fill_mask = new_mask;
        if (phase != PH_IDLE) begin
            fill_data[fill_base*W +: W]             = din_rise;
            fill_mask[fill_base*LANES +: LANES]     = ~ben_rise_n;
            fill_data[(fill_base+1)*W +: W]         = din_fall;
            fill_mask[(fill_base+1)*LANES +: LANES] = ~ben_fall_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            new_vld  <= 1'b0;
            new_addr <= '0;
            new_data <= '0;
            new_mask <= '0;
            old_vld  <= 1'b0;
            old_addr <= '0;
            old_data <= '0;
            old_mask <= '0;
        end else begin
            if (wr_valid)
                phase <= PH_LO;
            else if (phase == PH_LO)
                phase <= PH_HI;
            else
                phase <= PH_IDLE;

            if (wr_valid) begin
                old_vld  <= new_vld;
                old_addr <= new_addr;
                old_data <= fill_data;
                old_mask <= fill_mask;
                new_vld  <= 1'b1;
                new_addr <= wr_addr;
                new_data <= '0;
                new_mask <= '0;
            end else begin
                new_data <= fill_data;
                new_mask <= fill_mask;
            end
        end
    end

    // R2: commands keep the two-cycle spacing the beat slots need
    cmd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LO) |-> !wr_valid);

    // R3: an all-high enable set on the first beat leaves no mask bit
    abort_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LO && &ben_rise_n) |=> (new_mask[LANES-1:0] == '0));

    // R4: idle edges leave the newest slot untouched
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !wr_valid) |=> ($stable(new_mask) && $stable(new_data)));

    // R5: a new command ages the newest slot into the older one
    slot_age_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> (old_vld == $past(new_vld) && old_addr == $past(new_addr)));
endmodule

// File: rtl/lwb_merge.sv
module lwb_merge
    import lwb_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [BURST*LANE_W*LANES-1:0] rd_arr_data,
    input  logic                          new_vld,
    input  logic [ADDR_W-1:0]             new_addr,
    input  logic [BURST*LANE_W*LANES-1:0] new_data,
    input  logic [BURST*LANES-1:0]        new_mask,
    input  logic                          old_vld,
    input  logic [ADDR_W-1:0]             old_addr,
    input  logic [BURST*LANE_W*LANES-1:0] old_data,
    input  logic [BURST*LANES-1:0]        old_mask,
    output logic [BURST*LANE_W*LANES-1:0] fwd_data,
    output logic                          fwd_hit
);
    localparam int MW = BURST * LANES;

    logic hit_new, hit_old;

    assign hit_new = new_vld && (new_addr == rd_addr);
    assign hit_old = old_vld && (old_addr == rd_addr);
    assign fwd_hit = hit_new || hit_old;

    // byte g sits at bits g*LANE_W for every beat and lane
    for (genvar g = 0; g < MW; g++) begin : g_byte
        assign fwd_data[g*LANE_W +: LANE_W] =
            (hit_new && new_mask[g]) ? new_data[g*LANE_W +: LANE_W] :
            (hit_old && old_mask[g]) ? old_data[g*LANE_W +: LANE_W] :
                                       rd_arr_data[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lwb_late_write.sv
module lwb_late_write
    import lwb_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_valid,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [LANE_W*LANES-1:0]       din_rise,
    input  logic [LANE_W*LANES-1:0]       din_fall,
    input  logic [LANES-1:0]              ben_rise_n,
    input  logic [LANES-1:0]              ben_fall_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [BURST*LANE_W*LANES-1:0] rd_arr_data,
    output logic [BURST*LANE_W*LANES-1:0] fwd_data,
    output logic                          fwd_hit,
    output logic                          arr_we,
    output logic [ADDR_W-1:0]             arr_addr,
    output logic [BURST*LANE_W*LANES-1:0] arr_data,
    output logic [BURST*LANES-1:0]        arr_ben
);
    localparam int BW = BURST * LANE_W * LANES;
    localparam int MW = BURST * LANES;

    if (!(LANES == 2 || LANES == 4)) begin : g_lane_cfg
        $error("lwb_late_write supports 2 or 4 byte lanes");
    end

    logic              new_vld, old_vld;
    logic [ADDR_W-1:0] new_addr, old_addr;
    logic [BW-1:0]     new_data, old_data;
    logic [MW-1:0]     new_mask, old_mask;

    lwb_slots #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_slots (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr),
        .din_rise(din_rise), .din_fall(din_fall),
        .ben_rise_n(ben_rise_n), .ben_fall_n(ben_fall_n),
        .new_vld(new_vld), .new_addr(new_addr), .new_data(new_data), .new_mask(new_mask),
        .old_vld(old_vld), .old_addr(old_addr), .old_data(old_data), .old_mask(old_mask)
    );

    lwb_merge #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_merge (
        .rd_addr(rd_addr), .rd_arr_data(rd_arr_data),
        .new_vld(new_vld), .new_addr(new_addr), .new_data(new_data), .new_mask(new_mask),
        .old_vld(old_vld), .old_addr(old_addr), .old_data(old_data), .old_mask(old_mask),
        .fwd_data(fwd_data), .fwd_hit(fwd_hit)
    );

    // the older slot leaves in the same cycle that frees it
    assign arr_we   = wr_valid && old_vld;
    assign arr_addr = old_addr;
    assign arr_data = old_data;
    assign arr_ben  = old_mask;

    // R1: nothing is buffered right after reset
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> !fwd_hit);

    // R6: without a buffer match the array burst passes unchanged
    miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !fwd_hit |-> (fwd_data == rd_arr_data));

    // R5: a commit strobe never outlives its command cycle
    commit_once_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> !arr_we);
endmodule

// File: tb/sim_lwb_late_write.sv
module sim_lwb_late_write;
    localparam int CLK_PERIOD = 10;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int ADDR_W = 8;
    localparam int W  = LANE_W * LANES;
    localparam int BW = 4 * W;
    localparam int MW = 4 * LANES;
    localparam int DEPTH = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [W-1:0]      din_rise, din_fall;
    logic [LANES-1:0]  ben_rise_n, ben_fall_n;
    logic [ADDR_W-1:0] rd_addr;
    logic [BW-1:0]     rd_arr_data, fwd_data, arr_data;
    logic              fwd_hit, arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [MW-1:0]     arr_ben;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [BW-1:0] mem  [DEPTH];
    logic [BW-1:0] gold [DEPTH];

    // commit port snapshot taken in a command cycle
    logic              s_we;
    logic [ADDR_W-1:0] s_addr;
    logic [BW-1:0]     s_data;
    logic [MW-1:0]     s_ben;

    always #(CLK_PERIOD/2) clk = ~clk;

    lwb_late_write #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .din_rise(din_rise), .din_fall(din_fall),
        .ben_rise_n(ben_rise_n), .ben_fall_n(ben_fall_n),
        .rd_addr(rd_addr), .rd_arr_data(rd_arr_data),
        .fwd_data(fwd_data), .fwd_hit(fwd_hit),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data), .arr_ben(arr_ben)
    );

    // array model driven by the commit port
    always @(posedge clk) begin
        if (arr_we)
            for (int g = 0; g < MW; g++)
                if (arr_ben[g]) mem[arr_addr][g*LANE_W +: LANE_W] <= arr_data[g*LANE_W +: LANE_W];
    end
    assign rd_arr_data = mem[rd_addr];

    function automatic logic [BW-1:0] pat(int s);
        logic [BW-1:0] r;
        for (int g = 0; g < MW; g++) r[g*LANE_W +: LANE_W] = LANE_W'(s * 29 + g * 7 + 1);
        return r;
    endfunction

    function automatic void gold_apply(logic [ADDR_W-1:0] a, logic [BW-1:0] d, logic [MW-1:0] bn);
        for (int g = 0; g < MW; g++)
            if (!bn[g]) gold[a][g*LANE_W +: LANE_W] = d[g*LANE_W +: LANE_W];
    endfunction

    task automatic check(bit ok, string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle_junk();
        din_rise   = ~pat(99)[W-1:0];
        din_fall   = ~pat(98)[W-1:0];
        ben_rise_n = '0;
        ben_fall_n = '0;
    endtask

    task automatic drive_half(logic [BW-1:0] d, logic [MW-1:0] bn, int hi);
        din_rise   = d[(2*hi)*W +: W];
        din_fall   = d[(2*hi+1)*W +: W];
        ben_rise_n = bn[(2*hi)*LANES +: LANES];
        ben_fall_n = bn[(2*hi+1)*LANES +: LANES];
    endtask

    task automatic cmd(logic [ADDR_W-1:0] a);
        wr_valid = 1'b1;
        wr_addr  = a;
        #1;
        s_we = arr_we; s_addr = arr_addr; s_data = arr_data; s_ben = arr_ben;
    endtask

    // full write; ends one negedge after the last beat edge with junk on the lanes
    task automatic do_write(logic [ADDR_W-1:0] a, logic [BW-1:0] d, logic [MW-1:0] bn);
        @(negedge clk); cmd(a);
        @(negedge clk); wr_valid = 1'b0; drive_half(d, bn, 0);
        @(negedge clk); drive_half(d, bn, 1);
        @(negedge clk); drive_idle_junk();
        gold_apply(a, d, bn);
    endtask

    task automatic rd_check(logic [ADDR_W-1:0] a, bit exp_hit, string req);
        rd_addr = a;
        #1;
        check(fwd_hit == exp_hit, req, "hit", BW'(fwd_hit), BW'(exp_hit));
        check(fwd_data == gold[a], req, "data", fwd_data, gold[a]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rd_addr = 8'h05;
        #1;
        check(!fwd_hit, "R1", "hit after reset", BW'(fwd_hit), '0);
        check(!arr_we, "R1", "we after reset", BW'(arr_we), '0);
        check(fwd_data == rd_arr_data, "R1", "passthrough", fwd_data, rd_arr_data);
    endtask

    // A first write, read half way and right after the last beat
    task automatic t_beat_timing();
        logic [BW-1:0] d = pat(1);
        logic [BW-1:0] exp;
        @(negedge clk); cmd(8'h10);
        check(!s_we, "R5", "no commit on first write", BW'(s_we), '0);
        @(negedge clk); wr_valid = 1'b0; drive_half(d, '0, 0);
        @(negedge clk);
        rd_addr = 8'h10; #1;
        exp = gold[8'h10];
        exp[2*W-1:0] = d[2*W-1:0];
        check(fwd_data == exp, "R2", "beats 0/1 only after first edge", fwd_data, exp);
        drive_half(d, '0, 1);
        @(negedge clk); drive_idle_junk();
        gold_apply(8'h10, d, '0);
        rd_check(8'h10, 1'b1, "R8");
    endtask

    // rewrite A with mixed enables, then B which commits the first A
    task automatic t_bytes();
        logic [MW-1:0] bn = {4'b0111, 4'b0000, 4'b1111, 4'b1101};
        do_write(8'h10, pat(2), bn);
        check(!s_we, "R5", "no commit on second write", BW'(s_we), '0);
        rd_check(8'h10, 1'b1, "R7");
        do_write(8'h20, pat(3), '0);
        check(s_we, "R5", "commit strobe", BW'(s_we), BW'(1));
        check(s_addr == 8'h10, "R5", "commit addr", BW'(s_addr), BW'(8'h10));
        check(s_ben == '1, "R5", "commit mask", BW'(s_ben), BW'({MW{1'b1}}));
        check(s_data == pat(1), "R5", "commit data", s_data, pat(1));
        rd_check(8'h10, 1'b1, "R6");
        rd_check(8'h20, 1'b1, "R8");
    endtask

    task automatic t_idle();
        repeat (3) @(negedge clk);
        rd_check(8'h10, 1'b1, "R4");
        rd_check(8'h20, 1'b1, "R4");
        rd_check(8'h33, 1'b0, "R2");
    endtask

    // command on the same edge as the previous write's last beats
    task automatic t_b2b();
        logic [BW-1:0] dc = pat(4);
        logic [BW-1:0] dd = pat(5);
        logic [MW-1:0] bc = {4'b1010, 4'b0000, 4'b0101, 4'b0000};
        @(negedge clk); cmd(8'h30);
        check(s_we && s_addr == 8'h10, "R5", "commit second A", BW'(s_addr), BW'(8'h10));
        check(s_ben == {4'b1000, 4'b1111, 4'b0000, 4'b0010}, "R3", "masked commit",
              BW'(s_ben), BW'({4'b1000, 4'b1111, 4'b0000, 4'b0010}));
        @(negedge clk); wr_valid = 1'b0; drive_half(dc, bc, 0);
        @(negedge clk); drive_half(dc, bc, 1); cmd(8'h31);
        check(s_we && s_addr == 8'h20, "R5", "commit B", BW'(s_addr), BW'(8'h20));
        @(negedge clk); wr_valid = 1'b0; drive_half(dd, '0, 0);
        @(negedge clk); drive_half(dd, '0, 1);
        @(negedge clk); drive_idle_junk();
        gold_apply(8'h30, dc, bc);
        gold_apply(8'h31, dd, '0);
        rd_check(8'h30, 1'b1, "R2");
        rd_check(8'h31, 1'b1, "R8");
    endtask

    // push everything to the array and read it back with no buffer match
    task automatic t_drain();
        do_write(8'h40, pat(6), '0);
        do_write(8'h41, pat(7), '0);
        @(negedge clk);
        rd_check(8'h10, 1'b0, "R3");
        rd_check(8'h20, 1'b0, "R6");
        rd_check(8'h30, 1'b0, "R3");
        rd_check(8'h31, 1'b0, "R5");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]  = '0;
            gold[i] = '0;
        end
        rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; rd_addr = '0;
        din_rise = '0; din_fall = '0; ben_rise_n = '1; ben_fall_n = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_beat_timing();
        t_bytes();
        t_idle();
        t_b2b();
        t_drain();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule